// File: doc/BRIEF.md
# Interrupt Distributor with 16-bit CPU Target Masks

This block gathers interrupt sources and decides, for every CPU interface, whether that interface should be asked to take an interrupt. Sources fall into three classes by ID. IDs 0 to 15 are software interrupts, raised by a register write. IDs 16 to 31 are private wires, one set per CPU. IDs 32 and up are shared input lines, and any of them can be routed to any mix of up to 16 CPUs. For IDs 0 to 31 each CPU has its own copy of the enable, pending and active state. A shared line carries a 16-bit mask of target CPUs, so one register word holds the masks of two IDs.

Software reaches the block through a simple 32-bit register port. Every cycle can carry one request, tagged with the number of the CPU that makes it. No request is ever stalled. Read data is registered and appears on `bus_rdata` one cycle after the read request, and it holds until the next read. Each CPU interface reports that it has taken an interrupt on the acknowledge port, which makes the interrupt active. It reports the end of handling on the end-of-interrupt port, which clears the active state. The per-CPU `irq_req` outputs are plain registered levels.

Register map (byte offsets): control 0x000, type 0x004, enable set 0x100, enable clear 0x180, pending 0x200, active 0x300, targets 0x400, trigger configuration 0xC00, software interrupt 0xF00.

Top module: `irq_distributor`

## Requirements
- R1: Enable state changes only through write-one-to-set (0x100) and write-one-to-clear (0x180) words. ID n is bit n%32 of the word at (n/32)*4 in each bank. Zero bits leave the state unchanged, and a read of either bank returns the current enables.
- R2: Each shared ID has a 16-bit target mask at 0x400 + ((n*2) & ~3). An even ID uses bits 15:0 and an odd ID uses bits 31:16. The masks read back as written.
- R3: A target word covering IDs 0 to 31 (0x400 to 0x43F) reads as the requesting CPU's own bit (1 << cpu) in both halves. Writes to these words are ignored.
- R4: A write to 0xF00 sets software interrupt ID wdata[3:0] pending for every CPU c whose bit wdata[8+c] is set. CPUs not in the list are untouched.
- R5: The type register at 0x004 reports NUM_WORDS-1 in bits 4:0. The block implements min(NUM_WORDS*32, 510) IDs, and bits of absent IDs read as 0.
- R6: Bit 0 of the control register at 0x000 is the global enable, and it resets to 0. While it is 0, every `irq_req` is low from the next cycle on.
- R7: For IDs 0 to 31 the enable, pending (0x200) and active (0x300) bits are held per CPU. A CPU reads and changes only its own copy.
- R8: The configuration word at 0xC00 + (n/32)*4 holds one bit per ID: 1 means rising edge and 0 means level high. For IDs 0 to 31 it is fixed and reads 0x0000FFFF, and writes to it are ignored.
- R9: A rising-edge shared line latches pending on a 0-to-1 input transition, and the latch is cleared only by an acknowledge. A level shared line is pending exactly while its input is high.
- R10: `irq_req[c]` is high one cycle after the global enable is set and some enabled, pending, not active ID is targeted at CPU c. An acknowledge makes the ID active, and an end-of-interrupt clears the active state.
- R11: Read data appears the cycle after the read request. Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 4 | Number of the requesting CPU |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| shared_in | input | NUM_IDS-32 | Shared interrupt lines, bit i is ID 32+i |
| private_in | input | NUM_CPUS*16 | Private level lines, bits [c*16+k] are ID 16+k of CPU c |
| ack_sel | input | 1 | Acknowledge strobe |
| ack_cpu | input | 4 | Acknowledging CPU |
| ack_id | input | 9 | Acknowledged ID |
| eoi_sel | input | 1 | End-of-interrupt strobe |
| eoi_cpu | input | 4 | CPU ending the interrupt |
| eoi_id | input | 9 | ID being ended |
| irq_req | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
A wrong bank select or a wrong target half would raise a request on the wrong `irq_req` bit within two cycles of the stimulus. The bench therefore sweeps every shared ID through enable, trigger, acknowledge and end-of-interrupt, and checks the exact request vector at each step. A stale edge latch or active bit would show as a request that stays low after an end-of-interrupt, or one that comes back when it should not. Damage to the enable, target and pending storage shows on the next register read, one cycle later. Each CPU's banked copy is read separately so that leakage between CPUs is seen.

// File: rtl/idist_pkg.sv
package idist_pkg;

  localparam int ID_W  = 9;
  localparam int CPU_W = 4;
  localparam int TGT_W = 16;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_ENSET, RG_ENCLR,
    RG_PEND, RG_ACT, RG_TGT, RG_CFG, RG_SOFT
  } region_e;

  function automatic region_e decode_region(input logic [11:0] addr);
    region_e r;
    r = RG_NONE;
    if (addr == 12'h000)              r = RG_CTRL;
    else if (addr == 12'h004)         r = RG_TYPE;
    else if (addr[11:7] == 5'b00010)  r = RG_ENSET;
    else if (addr[11:7] == 5'b00011)  r = RG_ENCLR;
    else if (addr[11:8] == 4'h2)      r = RG_PEND;
    else if (addr[11:8] == 4'h3)      r = RG_ACT;
    else if (addr[11:10] == 2'b01)    r = RG_TGT;
    else if (addr[11:8] == 4'hC)      r = RG_CFG;
    else if (addr == 12'hF00)         r = RG_SOFT;
    return r;
  endfunction

endpackage

// File: rtl/idist_bank.sv
module idist_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] en_set,
  input  logic [31:0] en_clr,
  input  logic [15:0] sgi_set,
  input  logic [31:0] ack_mask,
  input  logic [31:0] eoi_mask,
  input  logic [15:0] prv_in,
  output logic [31:0] enable,
  output logic [31:0] pending,
  output logic [31:0] active,
  output logic        fire
);
  logic [31:0] en_q, act_q;
  logic [15:0] sgi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      act_q <= '0;
      sgi_q <= '0;
    end else begin
      en_q  <= (en_q & ~en_clr) | en_set;
      sgi_q <= (sgi_q & ~ack_mask[15:0]) | sgi_set;
      act_q <= (act_q & ~eoi_mask) | ack_mask;
    end
  end

  assign enable  = en_q;
  assign pending = {prv_in, sgi_q};
  assign active  = act_q;
  assign fire    = |(en_q & pending & ~act_q);
endmodule

// File: rtl/idist_shared.sv
module idist_shared #(
  parameter int NUM_SHARED = 32,
  parameter int NUM_CPUS   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SHARED-1:0]      line_in,
  input  logic                       en_set_we,
  input  logic                       en_clr_we,
  input  logic                       cfg_we,
  input  logic [4:0]                 word_idx,
  input  logic                       tgt_we,
  input  logic [7:0]                 tgt_idx,
  input  logic [31:0]                wdata,
  input  logic                       ack_we,
  input  logic [8:0]                 ack_idx,
  input  logic                       eoi_we,
  input  logic [8:0]                 eoi_idx,
  output logic [NUM_SHARED-1:0]      enable,
  output logic [NUM_SHARED-1:0]      pending,
  output logic [NUM_SHARED-1:0]      active,
  output logic [NUM_SHARED-1:0]      edge_cfg,
  output logic [NUM_SHARED-1:0][15:0] target,
  output logic [NUM_CPUS-1:0]        cpu_fire
);

  for (genvar i = 0; i < NUM_SHARED; i++) begin : g_line
    localparam int ID = i + 32;
    logic        en_r, cfg_r, prev_r, lat_r, act_r;
    logic [15:0] tgt_r;
    logic        word_hit, ack_hit, eoi_hit;

    assign word_hit = (word_idx == 5'(ID / 32));
    assign ack_hit  = ack_we && (ack_idx == 9'(ID));
    assign eoi_hit  = eoi_we && (eoi_idx == 9'(ID));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        cfg_r  <= 1'b0;
        prev_r <= 1'b0;
        lat_r  <= 1'b0;
        act_r  <= 1'b0;
        tgt_r  <= '0;
      end else begin
        if (en_set_we && word_hit && wdata[ID % 32])      en_r <= 1'b1;
        else if (en_clr_we && word_hit && wdata[ID % 32]) en_r <= 1'b0;
        if (cfg_we && word_hit) cfg_r <= wdata[ID % 32];
        if (tgt_we && tgt_idx == 8'(ID / 2)) tgt_r <= wdata[16*(ID % 2) +: 16];
        prev_r <= line_in[i];
        if (line_in[i] && !prev_r) lat_r <= 1'b1;
        else if (ack_hit)          lat_r <= 1'b0;
        if (ack_hit)      act_r <= 1'b1;
        else if (eoi_hit) act_r <= 1'b0;
      end
    end

    assign enable[i]   = en_r;
    assign edge_cfg[i] = cfg_r;
    assign pending[i]  = cfg_r ? lat_r : line_in[i];
    assign active[i]   = act_r;
    assign target[i]   = tgt_r;
  end

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      cpu_fire[c] = 1'b0;
      for (int i = 0; i < NUM_SHARED; i++)
        cpu_fire[c] = cpu_fire[c] | (enable[i] & pending[i] & ~active[i] & target[i][c]);
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_WORDS = 2,
  localparam int NUM_IDS    = (NUM_WORDS * 32 > 510) ? 510 : NUM_WORDS * 32,
  localparam int NUM_SHARED = NUM_IDS - 32,
  localparam int ALL_BITS   = NUM_WORDS * 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_write,
  input  logic [3:0]               bus_cpu,
  input  logic [11:0]              bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_SHARED-1:0]    shared_in,
  input  logic [NUM_CPUS*16-1:0]   private_in,
  input  logic                     ack_sel,
  input  logic [3:0]               ack_cpu,
  input  logic [8:0]               ack_id,
  input  logic                     eoi_sel,
  input  logic [3:0]               eoi_cpu,
  input  logic [8:0]               eoi_id,
  output logic [NUM_CPUS-1:0]      irq_req
);
  import idist_pkg::*;

  region_e     rg;
  logic        wr, cpu_ok, ack_ok, eoi_ok, ack_local, eoi_local;
  logic [4:0]  widx;
  logic [7:0]  tidx;
  logic        ctl_en;

  assign rg        = decode_region(bus_addr);
  assign wr        = bus_sel && bus_write;
  assign widx      = bus_addr[6:2];
  assign tidx      = bus_addr[9:2];
  assign cpu_ok    = ({1'b0, bus_cpu} < 5'(NUM_CPUS));
  assign ack_ok    = ack_sel && ({1'b0, ack_cpu} < 5'(NUM_CPUS));
  assign eoi_ok    = eoi_sel && ({1'b0, eoi_cpu} < 5'(NUM_CPUS));
  assign ack_local = (ack_id < 9'd32);
  assign eoi_local = (eoi_id < 9'd32);

  always_ff @(posedge clk) begin
    if (!rst_n)                      ctl_en <= 1'b0;
    else if (wr && rg == RG_CTRL)    ctl_en <= bus_wdata[0];
  end

  // Per-CPU banked state for IDs 0..31
  logic [NUM_CPUS-1:0][31:0] loc_en, loc_pend, loc_act;
  logic [NUM_CPUS-1:0]       loc_fire;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    logic        sel_c;
    logic [31:0] set_m, clr_m, ack_m, eoi_m;
    logic [15:0] sgi_m;

    assign sel_c = cpu_ok && (bus_cpu == 4'(c));
    assign set_m = (wr && rg == RG_ENSET && widx == 5'd0 && sel_c) ? bus_wdata : '0;
    assign clr_m = (wr && rg == RG_ENCLR && widx == 5'd0 && sel_c) ? bus_wdata : '0;
    assign sgi_m = (wr && rg == RG_SOFT && bus_wdata[8+c]) ? (16'd1 << bus_wdata[3:0]) : '0;
    assign ack_m = (ack_ok && ack_local && ack_cpu == 4'(c)) ? (32'd1 << ack_id[4:0]) : '0;
    assign eoi_m = (eoi_ok && eoi_local && eoi_cpu == 4'(c)) ? (32'd1 << eoi_id[4:0]) : '0;

    idist_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_set   (set_m),
      .en_clr   (clr_m),
      .sgi_set  (sgi_m),
      .ack_mask (ack_m),
      .eoi_mask (eoi_m),
      .prv_in   (private_in[c*16 +: 16]),
      .enable   (loc_en[c]),
      .pending  (loc_pend[c]),
      .active   (loc_act[c]),
      .fire     (loc_fire[c])
    );
  end

  // Shared lines, IDs 32 and up
  logic [NUM_SHARED-1:0]       sh_en, sh_pend, sh_act, sh_cfg;
  logic [NUM_SHARED-1:0][15:0] sh_tgt;
  logic [NUM_CPUS-1:0]         sh_fire;

  idist_shared #(.NUM_SHARED(NUM_SHARED), .NUM_CPUS(NUM_CPUS)) u_shared (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (shared_in),
    .en_set_we (wr && rg == RG_ENSET),
    .en_clr_we (wr && rg == RG_ENCLR),
    .cfg_we    (wr && rg == RG_CFG),
    .word_idx  (widx),
    .tgt_we    (wr && rg == RG_TGT),
    .tgt_idx   (tidx),
    .wdata     (bus_wdata),
    .ack_we    (ack_sel && !ack_local),
    .ack_idx   (ack_id),
    .eoi_we    (eoi_sel && !eoi_local),
    .eoi_idx   (eoi_id),
    .enable    (sh_en),
    .pending   (sh_pend),
    .active    (sh_act),
    .edge_cfg  (sh_cfg),
    .target    (sh_tgt),
    .cpu_fire  (sh_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_req <= '0;
    else        irq_req <= ctl_en ? (loc_fire | sh_fire) : '0;
  end

  // Read path
  logic [31:0]                 cur_en, cur_pend, cur_act;
  logic [ALL_BITS-1:0]         all_en, all_pend, all_act, all_cfg;
  logic [ALL_BITS-1:0][15:0]   tgt_full;
  logic [15:0]                 own_mask;
  logic [31:0]                 rd_word;

  always_comb begin
    cur_en = '0; cur_pend = '0; cur_act = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (bus_cpu == 4'(c)) begin
        cur_en   = loc_en[c];
        cur_pend = loc_pend[c];
        cur_act  = loc_act[c];
      end
    end
    own_mask = cpu_ok ? (16'd1 << bus_cpu) : 16'd0;
    all_en = '0; all_pend = '0; all_act = '0; all_cfg = '0; tgt_full = '0;
    all_en[31:0]   = cur_en;
    all_pend[31:0] = cur_pend;
    all_act[31:0]  = cur_act;
    all_cfg[31:0]  = 32'h0000_FFFF;
    all_en[NUM_IDS-1:32]   = sh_en;
    all_pend[NUM_IDS-1:32] = sh_pend;
    all_act[NUM_IDS-1:32]  = sh_act;
    all_cfg[NUM_IDS-1:32]  = sh_cfg;
    for (int i = 0; i < NUM_SHARED; i++) tgt_full[i+32] = sh_tgt[i];

    rd_word = '0;
    case (rg)
      RG_CTRL: rd_word = {31'd0, ctl_en};
      RG_TYPE: rd_word = {27'd0, 5'(NUM_WORDS - 1)};
      RG_ENSET, RG_ENCLR:
        if (int'(widx) < NUM_WORDS) rd_word = all_en[int'(widx)*32 +: 32];
      RG_PEND:
        if (int'(widx) < NUM_WORDS) rd_word = all_pend[int'(widx)*32 +: 32];
      RG_ACT:
        if (int'(widx) < NUM_WORDS) rd_word = all_act[int'(widx)*32 +: 32];
      RG_CFG:
        if (int'(widx) < NUM_WORDS) rd_word = all_cfg[int'(widx)*32 +: 32];
      RG_TGT:
        if (tidx < 8'd16) rd_word = {own_mask, own_mask};
        else if (int'(tidx) < NUM_WORDS*16)
          rd_word = {tgt_full[int'(tidx)*2 + 1], tgt_full[int'(tidx)*2]};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    bus_rdata <= '0;
    else if (bus_sel && !bus_write) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/idist_sva.sv
module idist_sva #(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_WORDS = 2,
  localparam int NUM_IDS    = (NUM_WORDS * 32 > 510) ? 510 : NUM_WORDS * 32,
  localparam int NUM_SHARED = NUM_IDS - 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic                      bus_write,
  input logic [3:0]                bus_cpu,
  input logic [11:0]               bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [31:0]               bus_rdata,
  input logic [NUM_CPUS-1:0]       irq_req,
  input logic                      ctl_en,
  input logic [NUM_CPUS-1:0][31:0] loc_pend,
  input logic [NUM_SHARED-1:0]     sh_en
);

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (irq_req == '0));

  assert_type_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write && bus_addr == 12'h004) |=> (bus_rdata[4:0] == 5'(NUM_WORDS - 1)));

  assert_own_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write && bus_addr[11:6] == 6'b010000 && ({1'b0, bus_cpu} < 5'(NUM_CPUS)))
    |=> (bus_rdata == {2{16'd1 << $past(bus_cpu)}}));

  assert_enable_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_write && bus_addr == 12'h184) |=> ((sh_en[31:0] & $past(bus_wdata)) == '0));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_sgi
    assert_soft_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_write && bus_addr == 12'hF00 && bus_wdata[8+c])
      |=> loc_pend[c][$past(bus_wdata[3:0])]);
  end
endmodule

bind irq_distributor idist_sva #(.NUM_CPUS(NUM_CPUS), .NUM_WORDS(NUM_WORDS)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_write (bus_write),
  .bus_cpu   (bus_cpu),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req),
  .ctl_en    (ctl_en),
  .loc_pend  (loc_pend),
  .sh_en     (sh_en)
);

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int NC = 4;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [31:0] shared_in = '0;
  logic [NC*16-1:0] private_in = '0;
  logic        ack_sel = 1'b0, eoi_sel = 1'b0;
  logic [3:0]  ack_cpu = '0, eoi_cpu = '0;
  logic [8:0]  ack_id = '0, eoi_id = '0;
  logic [NC-1:0] irq_req;
  logic [1:0]  irq_req_b;
  logic [477:0] big_lines = '0;
  logic [31:0]  big_priv = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_distributor #(.NUM_CPUS(NC), .NUM_WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .shared_in(shared_in), .private_in(private_in),
    .ack_sel(ack_sel), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .eoi_sel(eoi_sel), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id), .irq_req(irq_req));

  irq_distributor #(.NUM_CPUS(2), .NUM_WORDS(16)) uut_big (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .shared_in(big_lines), .private_in(big_priv),
    .ack_sel(1'b0), .ack_cpu(4'd0), .ack_id(9'd0),
    .eoi_sel(1'b0), .eoi_cpu(4'd0), .eoi_id(9'd0), .irq_req(irq_req_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int cpu, input int addr, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_cpu = 4'(cpu); bus_addr = 12'(addr); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input int cpu, input int addr, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_cpu = 4'(cpu); bus_addr = 12'(addr);
    @(negedge clk);
    bus_sel = 1'b0;
    a = rdata_a; b = rdata_b;
  endtask

  task automatic do_ack(input int cpu, input int id);
    @(negedge clk);
    ack_sel = 1'b1; ack_cpu = 4'(cpu); ack_id = 9'(id);
    @(negedge clk);
    ack_sel = 1'b0;
  endtask

  task automatic do_eoi(input int cpu, input int id);
    @(negedge clk);
    eoi_sel = 1'b1; eoi_cpu = 4'(cpu); eoi_id = 9'(id);
    @(negedge clk);
    eoi_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] tmask(input int id);
    return 16'd1 << (id % NC);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R10 reset request", 32'(irq_req), 0);
    bus_rd(0, 12'h000, ra, rb);
    chk("R6 reset control", ra, 0);
    bus_rd(0, 12'h004, ra, rb);
    chk("R5 type small", ra, 32'd1);
    chk("R5 type big", rb, 32'd15);
    bus_rd(0, 12'h800, ra, rb);
    chk("R11 unmapped read", ra, 0);

    // R7 / R1 banked enables
    for (int c = 0; c < NC; c++)
      bus_wr(c, 12'h100, (32'h11 << c) | (32'(c) << 20));
    for (int c = 0; c < NC; c++) begin
      bus_rd(c, 12'h180, ra, rb);
      chk("R7 banked enable", ra, (32'h11 << c) | (32'(c) << 20));
    end
    bus_wr(2, 12'h100, 32'h0);
    bus_wr(2, 12'h180, 32'h0);
    bus_rd(2, 12'h100, ra, rb);
    chk("R1 zero bits no effect", ra, (32'h11 << 2) | (32'd2 << 20));
    bus_wr(2, 12'h180, 32'h4);
    bus_rd(2, 12'h100, ra, rb);
    chk("R1 partial clear", ra, 32'h40 | (32'd2 << 20));
    for (int c = 0; c < NC; c++) bus_wr(c, 12'h180, 32'hFFFF_FFFF);

    // R3 local target words
    for (int c = 0; c < NC; c++) begin
      bus_wr(c, 12'h408, 32'hFFFF_FFFF);
      for (int w = 0; w < 16; w += 5) begin
        bus_rd(c, 12'h400 + w*4, ra, rb);
        chk("R3 own mask", ra, {2{16'd1 << c}});
      end
    end

    // R8 configuration
    bus_wr(0, 12'hC00, 32'h0);
    bus_rd(0, 12'hC00, ra, rb);
    chk("R8 local cfg fixed", ra, 32'h0000_FFFF);
    bus_wr(0, 12'hC04, 32'hAAAA_AAAA);
    bus_rd(1, 12'hC04, ra, rb);
    chk("R8 shared cfg", ra, 32'hAAAA_AAAA);

    // R2 target programming and readback
    for (int p = 16; p < 32; p++)
      bus_wr(0, 12'h400 + p*4, {tmask(2*p+1), tmask(2*p)});
    for (int p = 16; p < 32; p++) begin
      bus_rd(3, 12'h400 + p*4, ra, rb);
      chk("R2 target word", ra, {tmask(2*p+1), tmask(2*p)});
    end

    // R6 global enable and R9 / R10 sweep of shared lines
    bus_wr(0, 12'h000, 32'h1);
    for (int id = 32; id < 64; id++) begin
      logic [31:0] exp_req;
      exp_req = 32'(tmask(id));
      bus_wr(0, 12'h100 + (id/32)*4, 32'd1 << (id % 32));
      settle();
      chk("R10 no pending", 32'(irq_req), 0);
      if (id % 2 == 1) begin
        @(negedge clk); shared_in[id-32] = 1'b1;
        @(negedge clk); shared_in[id-32] = 1'b0;
        settle();
        chk("R9 edge latched", 32'(irq_req), exp_req);
        do_ack(id % NC, id);
        settle();
        chk("R10 active masks", 32'(irq_req), 0);
        bus_rd(id % NC, 12'h304, ra, rb);
        chk("R10 active bit", ra, 32'd1 << (id % 32));
        do_eoi(id % NC, id);
        settle();
        chk("R9 edge cleared by ack", 32'(irq_req), 0);
      end else begin
        @(negedge clk); shared_in[id-32] = 1'b1;
        settle();
        chk("R9 level pending", 32'(irq_req), exp_req);
        do_ack(id % NC, id);
        settle();
        chk("R10 active masks", 32'(irq_req), 0);
        do_eoi(id % NC, id);
        settle();
        chk("R9 level still high", 32'(irq_req), exp_req);
        @(negedge clk); shared_in[id-32] = 1'b0;
        settle();
        chk("R9 level dropped", 32'(irq_req), 0);
      end
      bus_wr(0, 12'h180 + (id/32)*4, 32'd1 << (id % 32));
      bus_rd(0, 12'h104, ra, rb);
      chk("R1 enable cleared", ra, 0);
    end

    // R4 software interrupts
    for (int c = 0; c < NC; c++) bus_wr(c, 12'h100, 32'h0000_FFFF);
    for (int id = 0; id < 16; id++) begin
      logic [3:0] lst;
      lst = 4'((id * 5 + 1) & 15);
      bus_wr(1, 12'hF00, (32'(lst) << 8) | 32'(id));
      settle();
      chk("R4 soft request", 32'(irq_req), 32'(lst));
      for (int c = 0; c < NC; c++) begin
        bus_rd(c, 12'h200, ra, rb);
        chk("R7 soft pending per cpu", ra, lst[c] ? (32'd1 << id) : 32'd0);
      end
      for (int c = 0; c < NC; c++)
        if (lst[c]) begin do_ack(c, id); do_eoi(c, id); end
      settle();
      chk("R4 soft done", 32'(irq_req), 0);
    end

    // R6 gating with a pending soft interrupt
    bus_wr(0, 12'h000, 32'h0);
    bus_wr(0, 12'hF00, (32'h4 << 8) | 32'd7);
    settle();
    chk("R6 gated", 32'(irq_req), 0);
    bus_wr(0, 12'h000, 32'h1);
    settle();
    chk("R6 enabled", 32'(irq_req), 32'h4);
    do_ack(2, 7); do_eoi(2, 7);

    // R7 private level line of one CPU
    bus_wr(1, 12'h100, 32'd1 << 20);
    @(negedge clk); private_in[1*16 + 4] = 1'b1;
    settle();
    chk("R7 private line", 32'(irq_req), 32'h2);
    @(negedge clk); private_in[1*16 + 4] = 1'b0;
    settle();
    chk("R7 private line low", 32'(irq_req), 0);

    // R5 cap at 510 IDs on the large configuration
    bus_wr(0, 12'h13C, 32'hFFFF_FFFF);
    bus_rd(0, 12'h13C, ra, rb);
    chk("R5 cap 510", rb, 32'h3FFF_FFFF);
    chk("R11 absent word small", ra, 0);

    finish_run();
  end
endmodule